// File: doc/BRIEF.md
# Two-Read One-Write Register File

An eight-entry, 16-bit register file with two independent read ports and one write port, meant to sit in a simple non-pipelined processor datapath. Each entry is a separate enable-gated storage register. A one-hot decoder turns the write index into per-entry load enables. Each read port picks one entry through its own 8-to-1 selector.

An entry loads only when three things are high in the same cycle: the decoder bit for that entry, the local write enable, and a global write enable. The global enable lets a single-step controller freeze all state while the clock keeps running. Reads are combinational from the read index and the current contents. A read of the entry being written in that cycle therefore returns the old contents, and the new value appears after the clock edge. There is no bypass.

Top module: `rf_2r1w`

## Requirements
- R1: After the active-low asynchronous reset rst_ni is released, every entry reads as zero on both read ports.
- R2: At a rising clock edge where we_i and gwe_i are both 1, the entry selected by waddr_i (index n selects entry n, 0 to 7) takes the value of wdata_i.
- R3: At an edge where we_i is 0, no entry changes, whatever the values of gwe_i, waddr_i and wdata_i.
- R4: At an edge where gwe_i is 0, no entry changes, even when we_i is 1.
- R5: During a cycle where an entry is being written, a read port addressing that entry returns the contents from before the edge. The new value is visible only after the edge.
- R6: A write changes only the addressed entry. The other seven entries keep their contents.
- R7: Each read port returns, in the same cycle and with no clock edge, the current contents of the entry named by its own index. The two ports work independently and may name the same entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low; clears all entries |
| gwe_i | input | 1 | Global write enable for single-step operation |
| we_i | input | 1 | Local write enable |
| waddr_i | input | 3 | Write entry index |
| wdata_i | input | 16 | Write data |
| raddr_a_i | input | 3 | Read port A entry index |
| raddr_b_i | input | 3 | Read port B entry index |
| rdata_a_o | output | 16 | Read port A data |
| rdata_b_o | output | 16 | Read port B data |

## Verification
The assertions assume that every input is a known value and is steady at each rising edge. They also assume that reset is released between edges, so the first edge after release sees entries that are still cleared. The bench changes inputs only on the falling edge and holds them until the next one. It drops reset at a falling edge, so it never breaks these assumptions. Random traffic draws the indices, data and both enables from $urandom. This exercises blocked writes, same-entry read-and-write, and both ports addressing one entry, along with directed sweeps of every index.

// File: rtl/rf_pkg.sv
package rf_pkg;
  localparam int unsigned DefDataW   = 16;
  localparam int unsigned DefNumRegs = 8;
endpackage

// File: rtl/rf_decoder.sv
module rf_decoder #(
  parameter int unsigned NumOut = 8,
  parameter int unsigned IdxW   = $clog2(NumOut)
) (
  input  logic [IdxW-1:0]   idx_i,
  output logic [NumOut-1:0] oh_o
);
  for (genvar g = 0; g < NumOut; g++) begin : g_bit
    assign oh_o[g] = (idx_i == IdxW'(g));
  end
endmodule

// File: rtl/rf_storage_reg.sv
module rf_storage_reg #(
  parameter int unsigned         W        = 16,
  parameter logic [W-1:0]        RstVal   = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic         gwe_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              q_o <= RstVal;
    else if (en_i && gwe_i)   q_o <= d_i;
  end
endmodule

// File: rtl/rf_read_mux.sv
module rf_read_mux #(
  parameter int unsigned W     = 16,
  parameter int unsigned NumIn = 8,
  parameter int unsigned IdxW  = $clog2(NumIn)
) (
  input  logic [NumIn-1:0][W-1:0] in_i,
  input  logic [IdxW-1:0]         sel_i,
  output logic [W-1:0]            out_o
);
  // AND-OR select keyed off a decoded select, no priority chain
  logic [NumIn-1:0] sel_oh;
  rf_decoder #(.NumOut(NumIn), .IdxW(IdxW)) u_sel_dec (.idx_i(sel_i), .oh_o(sel_oh));

  always_comb begin
    out_o = '0;
    for (int i = 0; i < NumIn; i++) begin
      out_o = out_o | (in_i[i] & {W{sel_oh[i]}});
    end
  end
endmodule

// File: rtl/rf_2r1w.sv
module rf_2r1w #(
  parameter int unsigned DataW   = rf_pkg::DefDataW,
  parameter int unsigned NumRegs = rf_pkg::DefNumRegs,
  localparam int unsigned AddrW  = $clog2(NumRegs)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             gwe_i,
  input  logic             we_i,
  input  logic [AddrW-1:0] waddr_i,
  input  logic [DataW-1:0] wdata_i,
  input  logic [AddrW-1:0] raddr_a_i,
  input  logic [AddrW-1:0] raddr_b_i,
  output logic [DataW-1:0] rdata_a_o,
  output logic [DataW-1:0] rdata_b_o
);
  logic [NumRegs-1:0]            wr_dec;
  logic [NumRegs-1:0]            wr_en;
  logic [NumRegs-1:0][DataW-1:0] entry_q;

  rf_decoder #(.NumOut(NumRegs), .IdxW(AddrW)) u_wr_dec (.idx_i(waddr_i), .oh_o(wr_dec));

  assign wr_en = wr_dec & {NumRegs{we_i}};

  for (genvar g = 0; g < NumRegs; g++) begin : g_entry
    rf_storage_reg #(.W(DataW), .RstVal('0)) u_reg (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .en_i  (wr_en[g]),
      .gwe_i (gwe_i),
      .d_i   (wdata_i),
      .q_o   (entry_q[g])
    );
  end

  rf_read_mux #(.W(DataW), .NumIn(NumRegs), .IdxW(AddrW)) u_rd_a (
    .in_i(entry_q), .sel_i(raddr_a_i), .out_o(rdata_a_o)
  );
  rf_read_mux #(.W(DataW), .NumIn(NumRegs), .IdxW(AddrW)) u_rd_b (
    .in_i(entry_q), .sel_i(raddr_b_i), .out_o(rdata_b_o)
  );
endmodule

// File: rtl/rf_2r1w_chk.sv
module rf_2r1w_chk #(
  parameter int unsigned DataW   = 16,
  parameter int unsigned NumRegs = 8,
  parameter int unsigned AddrW   = 3
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               gwe_i,
  input logic               we_i,
  input logic [AddrW-1:0]   waddr_i,
  input logic [DataW-1:0]   wdata_i,
  input logic [AddrW-1:0]   raddr_a_i,
  input logic [AddrW-1:0]   raddr_b_i,
  input logic [DataW-1:0]   rdata_a_o,
  input logic [DataW-1:0]   rdata_b_o,
  input logic [NumRegs-1:0] wr_en
);
  assert_reset_zero_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> (rdata_a_o == '0 && rdata_b_o == '0));

  assert_write_lands_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && gwe_i) |=> (raddr_a_i != $past(waddr_i) || rdata_a_o == $past(wdata_i)));

  assert_local_block_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> (raddr_b_i != $past(raddr_b_i) || rdata_b_o == $past(rdata_b_o)));

  assert_global_block_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && !gwe_i) |=> (raddr_a_i != $past(raddr_a_i) || rdata_a_o == $past(rdata_a_o)));

  // R6: at most one entry enabled, and a write elsewhere leaves port B's entry alone
  assert_single_target_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(wr_en));
  assert_others_kept_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (waddr_i != raddr_b_i) |=> (raddr_b_i != $past(raddr_b_i) || rdata_b_o == $past(rdata_b_o)));

  assert_ports_agree_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (raddr_a_i == raddr_b_i) |-> (rdata_a_o == rdata_b_o));
endmodule

bind rf_2r1w rf_2r1w_chk #(.DataW(DataW), .NumRegs(NumRegs), .AddrW(AddrW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .gwe_i(gwe_i), .we_i(we_i), .waddr_i(waddr_i),
  .wdata_i(wdata_i), .raddr_a_i(raddr_a_i), .raddr_b_i(raddr_b_i),
  .rdata_a_o(rdata_a_o), .rdata_b_o(rdata_b_o), .wr_en(wr_en)
);

// File: tb/rf_2r1w_tb.sv
module rf_2r1w_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        gwe_i = 1'b0, we_i = 1'b0;
  logic [2:0]  waddr_i = '0, raddr_a_i = '0, raddr_b_i = '0;
  logic [15:0] wdata_i = '0;
  logic [15:0] rdata_a_o, rdata_b_o;

  logic [15:0] model [8];
  int unsigned n_checks = 0, n_err = 0;
  bit done = 0;

  always #4 clk_i = ~clk_i;

  rf_2r1w u_dut (.*);

  function automatic logic [15:0] expect_rd(input logic [2:0] idx);
    return model[idx];
  endfunction

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Called just after a falling edge: apply, check pre-edge reads, cross edge, update model.
  task automatic step(input string tag, input bit g, input bit w, input logic [2:0] wa,
                      input logic [15:0] wd, input logic [2:0] ra, input logic [2:0] rb);
    gwe_i = g; we_i = w; waddr_i = wa; wdata_i = wd; raddr_a_i = ra; raddr_b_i = rb;
    #1;
    check(tag, rdata_a_o, expect_rd(ra));
    check(tag, rdata_b_o, expect_rd(rb));
    @(posedge clk_i);
    if (g && w) model[wa] = wd;
    @(negedge clk_i);
  endtask

  initial begin
    int unsigned seed;
    seed = 32'd1234;
    void'($urandom(seed));
    for (int i = 0; i < 8; i++) model[i] = '0;
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    // R1: every entry is zero after reset
    for (int i = 0; i < 8; i++) begin
      raddr_a_i = 3'(i); raddr_b_i = 3'(7 - i); #1;
      check("R1", rdata_a_o, 16'h0000);
      check("R1", rdata_b_o, 16'h0000);
    end
    // R2/R6: write each entry with a distinct pattern
    for (int i = 0; i < 8; i++) step("R2", 1, 1, 3'(i), 16'hA500 + 16'(i * 17), 3'(i), 3'((i + 1) % 8));
    for (int i = 0; i < 8; i++) step("R6", 0, 0, 3'(i), 16'hFFFF, 3'(i), 3'(7 - i));
    // R5: read-during-write of the same entry shows old data; next cycle shows new
    step("R5", 1, 1, 3'd3, 16'h1234, 3'd3, 3'd3);
    step("R5", 0, 0, 3'd0, 16'h0000, 3'd3, 3'd3);
    // R4: global enable low blocks the write
    step("R4", 0, 1, 3'd5, 16'hDEAD, 3'd5, 3'd5);
    step("R4", 0, 0, 3'd5, 16'hBEEF, 3'd5, 3'd0);
    // R3: local enable low blocks the write
    step("R3", 1, 0, 3'd6, 16'hCAFE, 3'd6, 3'd6);
    step("R3", 1, 0, 3'd6, 16'h0001, 3'd6, 3'd1);
    // R2 edge data values on boundary indices
    step("R2", 1, 1, 3'd0, 16'hFFFF, 3'd7, 3'd0);
    step("R2", 1, 1, 3'd7, 16'h0000, 3'd0, 3'd7);
    step("R7", 0, 0, 3'd0, 16'h0000, 3'd0, 3'd7);
    // Random mix: R2..R7
    for (int k = 0; k < 2000; k++) begin
      logic [2:0] wa;
      wa = 3'($urandom);
      step("R7", 1'($urandom), 1'($urandom), wa, 16'($urandom),
           ($urandom % 3 == 0) ? wa : 3'($urandom), 3'($urandom));
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      n_checks++; n_err++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_checks);
      $finish;
    end
  end
endmodule